// File: doc/BRIEF.md
# Gated / Zero-Stuffing Sample Entry Controller

This block stands at the head of a sample-processing pipeline and decides, on every clock, what enters that pipeline. One active-low strobe pin, `take_n`, is sampled on the rising clock edge. A configuration bit selects how that strobe is read.

In gated mode, the strobe acts as a sample gate. The pipeline receives a new I/Q word only on cycles where `take_n` is low. On all other cycles the output holds its value and is marked not valid. The effective pipeline rate therefore equals the rate of low strobes.

In interpolated mode, every cycle produces a valid output. A low strobe passes the input word through, and a high strobe injects a zero word. This raises the pipeline rate by inserting zeroes between real samples.

In both modes a separate strobe, `osc_step`, tells a downstream oscillator to advance. It is asserted only when real input data was taken. The oscillator therefore runs at the true input rate, not at the clock rate.

The output stream is a valid-only stream. There is no ready and no back-pressure, so the consumer must accept every cycle on which `out_vld` is high. The input side has no handshake beyond `take_n`. Every result is registered once, so it appears one clock after the edge that sampled the inputs.

Top module: `icz_input_ctl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces `out_i` and `out_q` to zero and deasserts `out_vld` and `osc_step` after that edge.
- R2: In gated mode (`mode_interp`=0), a low `take_n` at an edge makes `out_vld`=1 and `out_i`/`out_q` equal the `in_i`/`in_q` sampled at that edge, after that edge.
- R3: In gated mode, a high `take_n` at an edge makes `out_vld`=0 and leaves `out_i`/`out_q` unchanged after that edge.
- R4: In interpolated mode (`mode_interp`=1), a high `take_n` at an edge makes `out_vld`=1 with `out_i`=`out_q`=0 after that edge.
- R5: In interpolated mode, a low `take_n` at an edge makes `out_vld`=1 with `out_i`/`out_q` equal to the sampled inputs after that edge.
- R6: `osc_step` is 1 after an edge exactly when `take_n` was low at that edge, in either mode, and is 0 otherwise.
- R7: `mode_interp` is sampled at the same edge as `take_n`. A change of mode governs the very next result, with no settling cycles.
- R8: Full-scale signed words (most negative and most positive two's-complement values of width DATA_W) pass through unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| take_n | input | 1 | Active-low sample strobe |
| mode_interp | input | 1 | 0 = gated mode, 1 = interpolated (zero-stuffing) mode |
| in_i | input | DATA_W | Signed in-phase input word |
| in_q | input | DATA_W | Signed quadrature input word |
| out_i | output | DATA_W | Signed in-phase pipeline word |
| out_q | output | DATA_W | Signed quadrature pipeline word |
| out_vld | output | 1 | Pipeline word valid |
| osc_step | output | 1 | Oscillator advance strobe |

## Verification
Every result (`out_i`, `out_q`, `out_vld`, `osc_step`) is due exactly one clock after the edge that sampled `take_n`, `mode_interp` and the input word.

The bench changes inputs on the falling edge. It then waits for the next rising edge and samples one time unit later. Each vector's expected values therefore describe the state that follows that single edge.

Expected held values in gated mode come from the previous vector's result, written into the table by hand. The checker properties use the same one-edge offset through `|=>` and `$past`.

// File: rtl/icz_pkg.sv
package icz_pkg;
  localparam int DEF_DATA_W = 12;
  localparam int LANES      = 2;  // I and Q
  typedef enum logic {
    MODE_GATED  = 1'b0,
    MODE_INTERP = 1'b1
  } icz_mode_e;
endpackage

// File: rtl/icz_decide.sv
// Combinational decision: what the next pipeline word is and which strobes fire.
module icz_decide
  import icz_pkg::*;
(
  input  logic take_n,
  input  logic mode_interp,
  output logic load,
  output logic zero,
  output logic vld_d,
  output logic step_d
);
  icz_mode_e mode;
  logic      taken;

  always_comb begin
    mode   = icz_mode_e'(mode_interp);
    taken  = ~take_n;
    step_d = taken;
    zero   = 1'b0;
    load   = 1'b0;
    unique case (mode)
      MODE_GATED: begin
        load = taken;
      end
      MODE_INTERP: begin
        load = 1'b1;
        zero = ~taken;
      end
      default: begin
        load = 1'b0;
      end
    endcase
    vld_d = load;
  end
endmodule

// File: rtl/icz_lane.sv
// One data lane: registered word, loads the input or a zero, else holds.
module icz_lane #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         zero,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= zero ? '0 : din;
  end
endmodule

// File: rtl/icz_strobe.sv
// Registered strobes, aligned with the lane registers.
module icz_strobe (
  input  logic clk,
  input  logic rst,
  input  logic vld_d,
  input  logic step_d,
  output logic vld_q,
  output logic step_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      step_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      step_q <= step_d;
    end
  end
endmodule

// File: rtl/icz_input_ctl.sv
module icz_input_ctl
  import icz_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take_n,
  input  logic                     mode_interp,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic                     out_vld,
  output logic                     osc_step
);
  logic load, zero, vld_d, step_d;
  logic [LANES-1:0][DATA_W-1:0] lane_in;
  logic [LANES-1:0][DATA_W-1:0] lane_out;

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  icz_decide u_decide (
    .take_n      (take_n),
    .mode_interp (mode_interp),
    .load        (load),
    .zero        (zero),
    .vld_d       (vld_d),
    .step_d      (step_d)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    icz_lane #(.W(DATA_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .zero (zero),
      .din  (lane_in[g]),
      .dout (lane_out[g])
    );
  end

  icz_strobe u_strobe (
    .clk    (clk),
    .rst    (rst),
    .vld_d  (vld_d),
    .step_d (step_d),
    .vld_q  (out_vld),
    .step_q (osc_step)
  );

  assign out_i = lane_out[0];
  assign out_q = lane_out[1];
endmodule

// File: rtl/icz_input_ctl_chk.sv
module icz_input_ctl_chk #(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     take_n,
  input logic                     mode_interp,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q,
  input logic                     out_vld,
  input logic                     osc_step
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_vld && !osc_step && out_i == '0 && out_q == '0));

  a_r2_gated_accept: assert property (@(posedge clk) disable iff (rst)
    (!mode_interp && !take_n) |=>
      (out_vld && out_i == $past(in_i) && out_q == $past(in_q)));

  a_r3_gated_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode_interp && take_n) |=> (!out_vld && $stable(out_i) && $stable(out_q)));

  a_r4_interp_zero: assert property (@(posedge clk) disable iff (rst)
    (mode_interp && take_n) |=> (out_vld && out_i == '0 && out_q == '0));

  a_r5_interp_pass: assert property (@(posedge clk) disable iff (rst)
    (mode_interp && !take_n) |=>
      (out_vld && out_i == $past(in_i) && out_q == $past(in_q)));

  a_r6_step_on_take: assert property (@(posedge clk) disable iff (rst)
    !take_n |=> osc_step);

  a_r6_no_step_idle: assert property (@(posedge clk) disable iff (rst)
    take_n |=> !osc_step);
endmodule

bind icz_input_ctl icz_input_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .take_n(take_n), .mode_interp(mode_interp),
  .in_i(in_i), .in_q(in_q), .out_i(out_i), .out_q(out_q),
  .out_vld(out_vld), .osc_step(osc_step)
);

// File: tb/tb_icz_input_ctl.sv
`timescale 1ns/1ps
module tb_icz_input_ctl;
  localparam int W  = 12;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst, take_n, mode_interp, out_vld, osc_step;
  logic signed [W-1:0] in_i, in_q, out_i, out_q;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  icz_input_ctl #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .take_n(take_n), .mode_interp(mode_interp),
    .in_i(in_i), .in_q(in_q), .out_i(out_i), .out_q(out_q),
    .out_vld(out_vld), .osc_step(osc_step)
  );

  // Vector table; the expected values describe the state after the sampling edge.
  //  v0 R2 gated take | v1,v2 R3 gated hold | v3 R8 full scale gated
  //  v4 R4 interp zero | v5 R5 interp pass | v6 R4 | v7 R7 mode switch, hold
  //  v8 R7 gated take | v9 R8 full scale interp; osc_step is checked as R6
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 0, 1};
  localparam int V_TKN  [NV] = '{0, 1, 1, 0, 1, 0, 1, 1, 0, 0};
  localparam int V_II   [NV] = '{100, 7, 9, -2048, 33, 33, 1, 5, -1, 2047};
  localparam int V_IQ   [NV] = '{-5, 8, 9, 2047, 44, 44, 1, 5, 1, -2048};
  localparam int E_VLD  [NV] = '{1, 0, 0, 1, 1, 1, 1, 0, 1, 1};
  localparam int E_I    [NV] = '{100, 100, 100, -2048, 0, 33, 0, 0, -1, 2047};
  localparam int E_Q    [NV] = '{-5, -5, -5, 2047, 0, 44, 0, 0, 1, -2048};
  localparam int E_STEP [NV] = '{1, 0, 0, 1, 0, 1, 0, 0, 1, 1};
  localparam int V_REQ  [NV] = '{2, 3, 3, 8, 4, 5, 4, 7, 7, 8};

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; take_n = 1'b0; mode_interp = 1'b1; in_i = 12'sd77; in_q = 12'sd66;
    step_edge();
    step_edge();
    // R1: reset state
    chk("R1 vld", int'(out_vld), 0);
    chk("R1 step", int'(osc_step), 0);
    chk("R1 i", int'(out_i), 0);
    chk("R1 q", int'(out_q), 0);

    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      mode_interp = V_MODE[k][0];
      take_n      = V_TKN[k][0];
      in_i        = W'(V_II[k]);
      in_q        = W'(V_IQ[k]);
      step_edge();
      chk($sformatf("R%0d vec%0d vld", V_REQ[k], k), int'(out_vld), E_VLD[k]);
      chk($sformatf("R%0d vec%0d i", V_REQ[k], k), int'(out_i), E_I[k]);
      chk($sformatf("R%0d vec%0d q", V_REQ[k], k), int'(out_q), E_Q[k]);
      chk($sformatf("R6 vec%0d step", k), int'(osc_step), E_STEP[k]);
      @(negedge clk);
    end

    // R1: reset mid-stream wins over an active take in gated mode
    mode_interp = 1'b0; take_n = 1'b0; in_i = 12'sd300; in_q = -12'sd300; rst = 1'b1;
    step_edge();
    chk("R1 mid vld", int'(out_vld), 0);
    chk("R1 mid step", int'(osc_step), 0);
    chk("R1 mid i", int'(out_i), 0);
    chk("R1 mid q", int'(out_q), 0);

    // R3: long gated idle run keeps the word and produces no strobes
    @(negedge clk);
    rst = 1'b0;
    step_edge();  // gated take of 300/-300
    chk("R2 after reset i", int'(out_i), 300);
    @(negedge clk);
    take_n = 1'b1; in_i = 12'sd1; in_q = 12'sd1;
    for (int k = 0; k < 5; k++) begin
      step_edge();
      chk("R3 idle vld", int'(out_vld), 0);
      chk("R6 idle step", int'(osc_step), 0);
      chk("R3 idle i", int'(out_i), 300);
      chk("R3 idle q", int'(out_q), -300);
    end

    // R7 / R4: switch to interp while idle, zero appears immediately
    @(negedge clk);
    mode_interp = 1'b1;
    step_edge();
    chk("R7 switch vld", int'(out_vld), 1);
    chk("R4 switch i", int'(out_i), 0);
    chk("R6 switch step", int'(osc_step), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule